// File: doc/BRIEF.md
# Indexed Chipset Configuration Port

This block gives a processor bus a small configuration space. An index register at I/O address 0x22 selects one of 256 configuration slots, and the data port at 0x23 reads or writes the slot the index selects. Only a fixed set of slots can be written. A write to any other slot is dropped. Slots that cannot be written return a fixed value: a constant for the version, DMA-wait and status slots, and 0xFF for every unused slot.

A second port at 0x92 holds a system-control latch. Bit 1 of that latch drives the alternate A20 gate. A rising edge on bit 0 produces a one-cycle soft-reset pulse for the CPU.

The stored configuration bytes leave the block as plain outputs for the memory-decode logic. A one-cycle remap strobe tells that logic when the DRAM layout or the extended-boundary slot has changed, so it can recompute its state. Reads are combinational: `io_rdata` follows `io_addr` and the current index in the same cycle. Writes take effect at the clock edge where `io_wr` is high.

Top module: `cfg_index_port`

## Requirements
- R1: A write to port 0x22 loads the index. A write to port 0x23 updates the selected slot, and a read of 0x23 returns it. Stored values appear from the cycle after the write edge.
- R2: After reset, the slots read as follows: 0x01=0x00, 0x40=0x0A, 0x41=0x02, 0x42=0x80, 0x43=0x37, 0x44=0x00, 0x45=0x02, 0x46=0x00, 0x47=0x00, 0x48=0xC0, 0x49=0x00, 0x4A..0x4C=0x00. Every other index reads 0xFF. The index itself resets to 0.
- R3: Only these slots are writable: 0x41 clock, 0x42 peripheral, 0x44 power, 0x45 DRAM layout, 0x46 boundary, 0x47 paging control, 0x48 ROM enable, 0x49 write protect, and 0x4A..0x4C shadow enables. A data write to any other index leaves every read value unchanged.
- R4: A write to the power slot (0x44) stores only bit 6. All other bits read back as 0.
- R5: A read of the status slot (0x43) returns its constant 0x37 with bit 6 replaced by bit 1 of the 0x92 latch.
- R6: The 0x92 latch resets to 0x00, and a read of 0x92 returns the last byte written there. Output `a20_alt` equals bit 1 of the latch.
- R7: When a write to 0x92 sets bit 0 and the latch had bit 0 clear, `cpu_soft_reset` is high for exactly the one cycle after the write edge. A write that leaves bit 0 at 1 gives no pulse.
- R8: A data write whose index is 0x45 or 0x46 raises `remap_stb` for exactly the one cycle after the write edge. No other write raises it.
- R9: A read of any address other than 0x23 and 0x92 returns 0xFF.
- R10: The `cfg_*` outputs carry the stored clock, peripheral, paging, power, DRAM, boundary, ROM-enable and write-protect bytes. `cfg_shadow` carries shadow slot k in bits 8k+7..8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Combinational read data |
| cfg_clock | output | 8 | Clock-control byte |
| cfg_periph | output | 8 | Peripheral-control byte |
| cfg_paging | output | 8 | Paging-control byte |
| cfg_power | output | 8 | Power byte (bit 6 only) |
| cfg_dram | output | 8 | DRAM-layout byte |
| cfg_bound | output | 8 | Extended-boundary byte |
| cfg_romen | output | 8 | ROM-enable byte |
| cfg_wprot | output | 8 | Write-protect byte |
| cfg_shadow | output | 24 | Shadow-enable bytes, slot 0 lowest |
| a20_alt | output | 1 | Alternate A20 gate |
| cpu_soft_reset | output | 1 | One-cycle CPU reset pulse |
| remap_stb | output | 1 | One-cycle remap strobe |

## Verification
A corrupted index or a wrong write filter shows up on the very next read of 0x23. Either a dropped write reads back as its old value, or an unused slot stops reading 0xFF. For this reason the bench writes a distinct pattern to all 256 indices and reads each one back at once. A wrong edge detector on the 0x92 latch shows within one cycle, as a missing, doubled or spurious `cpu_soft_reset`. A stale latch bit shows in both `a20_alt` and status bit 6, so both are compared after each latch write.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int DW = 8;

    localparam logic [7:0] IX_DMAWAIT = 8'h01;
    localparam logic [7:0] IX_VERSION = 8'h40;
    localparam logic [7:0] IX_CLOCK   = 8'h41;
    localparam logic [7:0] IX_PERIPH  = 8'h42;
    localparam logic [7:0] IX_STATUS  = 8'h43;
    localparam logic [7:0] IX_POWER   = 8'h44;
    localparam logic [7:0] IX_DRAM    = 8'h45;
    localparam logic [7:0] IX_BOUND   = 8'h46;
    localparam logic [7:0] IX_PAGING  = 8'h47;
    localparam logic [7:0] IX_ROMEN   = 8'h48;
    localparam logic [7:0] IX_WPROT   = 8'h49;
    localparam logic [7:0] IX_SHADOW0 = 8'h4A;

    localparam logic [7:0] RV_DMAWAIT = 8'h00;
    localparam logic [7:0] RV_VERSION = 8'h0A;
    localparam logic [7:0] RV_CLOCK   = 8'h02;
    localparam logic [7:0] RV_PERIPH  = 8'h80;
    localparam logic [7:0] RV_STATUS  = 8'h37;
    localparam logic [7:0] RV_POWER   = 8'h00;
    localparam logic [7:0] RV_DRAM    = 8'h02;
    localparam logic [7:0] RV_BOUND   = 8'h00;
    localparam logic [7:0] RV_PAGING  = 8'h00;
    localparam logic [7:0] RV_ROMEN   = 8'hC0;
    localparam logic [7:0] RV_WPROT   = 8'h00;
    localparam logic [7:0] RV_SHADOW  = 8'h00;
    localparam logic [7:0] RV_UNUSED  = 8'hFF;

    localparam logic [7:0] POWER_KEEP = 8'h40;
    localparam int         STATUS_LIVE_BIT = 6;
    localparam int         LATCH_A20_BIT   = 1;
    localparam int         LATCH_RST_BIT   = 0;

    typedef struct packed {
        logic [DW-1:0] clock;
        logic [DW-1:0] periph;
        logic [DW-1:0] paging;
        logic [DW-1:0] power;
        logic [DW-1:0] dram;
        logic [DW-1:0] bound;
        logic [DW-1:0] romen;
        logic [DW-1:0] wprot;
    } core_regs_t;

    typedef struct packed {
        logic [DW-1:0] index;
        core_regs_t    core;
        logic          stb;
    } regfile_state_t;

    typedef struct packed {
        logic [DW-1:0] latch;
        logic          pulse;
    } sysctl_state_t;

    localparam core_regs_t CORE_RESET = '{
        clock:  RV_CLOCK,
        periph: RV_PERIPH,
        paging: RV_PAGING,
        power:  RV_POWER,
        dram:   RV_DRAM,
        bound:  RV_BOUND,
        romen:  RV_ROMEN,
        wprot:  RV_WPROT
    };
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] index_q,
    output core_regs_t    core_q,
    output logic          remap_stb
);
    regfile_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (idx_wr) begin
            st_d.index = wdata;
        end
        if (dat_wr) begin
            case (st_q.index)
                IX_CLOCK:  st_d.core.clock  = wdata;
                IX_PERIPH: st_d.core.periph = wdata;
                IX_PAGING: st_d.core.paging = wdata;
                IX_POWER:  st_d.core.power  = wdata & POWER_KEEP;
                IX_DRAM: begin
                    st_d.core.dram = wdata;
                    st_d.stb       = 1'b1;
                end
                IX_BOUND: begin
                    st_d.core.bound = wdata;
                    st_d.stb        = 1'b1;
                end
                IX_ROMEN:  st_d.core.romen  = wdata;
                IX_WPROT:  st_d.core.wprot  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{index: '0, core: CORE_RESET, stb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign index_q   = st_q.index;
    assign core_q    = st_q.core;
    assign remap_stb = st_q.stb;
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_SHADOW = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dat_wr,
    input  logic [DW-1:0]            index,
    input  logic [DW-1:0]            wdata,
    output logic [NUM_SHADOW*DW-1:0] shadow_q
);
    for (genvar g = 0; g < NUM_SHADOW; g++) begin : g_slot
        localparam logic [DW-1:0] MY_IX = IX_SHADOW0 + DW'(g);
        logic [DW-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = sh_q;
            if (dat_wr && (index == MY_IX)) begin
                sh_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= RV_SHADOW;
            end else begin
                sh_q <= sh_d;
            end
        end

        assign shadow_q[g*DW +: DW] = sh_q;
    end
endmodule

// File: rtl/cfg_sysctl_latch.sv
module cfg_sysctl_latch
    import cfg_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] latch_q,
    output logic          a20,
    output logic          soft_reset
);
    sysctl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr) begin
            st_d.latch = wdata;
            st_d.pulse = wdata[LATCH_RST_BIT] & ~st_q.latch[LATCH_RST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{latch: '0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_q    = st_q.latch;
    assign a20        = st_q.latch[LATCH_A20_BIT];
    assign soft_reset = st_q.pulse;
endmodule

// File: rtl/cfg_readmux.sv
module cfg_readmux
    import cfg_port_pkg::*;
#(
    parameter int            NUM_SHADOW  = 3,
    parameter int            AW          = 16,
    parameter logic [AW-1:0] DATA_PORT   = 16'h0023,
    parameter logic [AW-1:0] SYSCTL_PORT = 16'h0092
) (
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            index,
    input  core_regs_t               core,
    input  logic [NUM_SHADOW*DW-1:0] shadow,
    input  logic [DW-1:0]            latch,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] slot_val;

    always_comb begin
        slot_val = RV_UNUSED;
        case (index)
            IX_DMAWAIT: slot_val = RV_DMAWAIT;
            IX_VERSION: slot_val = RV_VERSION;
            IX_CLOCK:   slot_val = core.clock;
            IX_PERIPH:  slot_val = core.periph;
            IX_STATUS: begin
                slot_val = RV_STATUS;
                slot_val[STATUS_LIVE_BIT] = latch[LATCH_A20_BIT];
            end
            IX_POWER:   slot_val = core.power;
            IX_DRAM:    slot_val = core.dram;
            IX_BOUND:   slot_val = core.bound;
            IX_PAGING:  slot_val = core.paging;
            IX_ROMEN:   slot_val = core.romen;
            IX_WPROT:   slot_val = core.wprot;
            default: begin
                for (int k = 0; k < NUM_SHADOW; k++) begin
                    if (index == IX_SHADOW0 + DW'(k)) begin
                        slot_val = shadow[k*DW +: DW];
                    end
                end
            end
        endcase
    end

    always_comb begin
        if (addr == DATA_PORT) begin
            rdata = slot_val;
        end else if (addr == SYSCTL_PORT) begin
            rdata = latch;
        end else begin
            rdata = RV_UNUSED;
        end
    end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int            NUM_SHADOW  = 3,
    parameter int            AW          = 16,
    parameter logic [AW-1:0] INDEX_PORT  = 16'h0022,
    parameter logic [AW-1:0] DATA_PORT   = 16'h0023,
    parameter logic [AW-1:0] SYSCTL_PORT = 16'h0092
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_wr,
    input  logic [AW-1:0]            io_addr,
    input  logic [7:0]               io_wdata,
    output logic [7:0]               io_rdata,
    output logic [7:0]               cfg_clock,
    output logic [7:0]               cfg_periph,
    output logic [7:0]               cfg_paging,
    output logic [7:0]               cfg_power,
    output logic [7:0]               cfg_dram,
    output logic [7:0]               cfg_bound,
    output logic [7:0]               cfg_romen,
    output logic [7:0]               cfg_wprot,
    output logic [NUM_SHADOW*8-1:0]  cfg_shadow,
    output logic                     a20_alt,
    output logic                     cpu_soft_reset,
    output logic                     remap_stb
);
    logic          idx_wr, dat_wr, sys_wr;
    logic [DW-1:0] index_q;
    logic [DW-1:0] latch_q;
    core_regs_t    core_q;

    assign idx_wr = io_wr && (io_addr == INDEX_PORT);
    assign dat_wr = io_wr && (io_addr == DATA_PORT);
    assign sys_wr = io_wr && (io_addr == SYSCTL_PORT);

    cfg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .dat_wr    (dat_wr),
        .wdata     (io_wdata),
        .index_q   (index_q),
        .core_q    (core_q),
        .remap_stb (remap_stb)
    );

    cfg_shadow_bank #(.NUM_SHADOW(NUM_SHADOW)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .dat_wr   (dat_wr),
        .index    (index_q),
        .wdata    (io_wdata),
        .shadow_q (cfg_shadow)
    );

    cfg_sysctl_latch u_sysctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (sys_wr),
        .wdata      (io_wdata),
        .latch_q    (latch_q),
        .a20        (a20_alt),
        .soft_reset (cpu_soft_reset)
    );

    cfg_readmux #(
        .NUM_SHADOW  (NUM_SHADOW),
        .AW          (AW),
        .DATA_PORT   (DATA_PORT),
        .SYSCTL_PORT (SYSCTL_PORT)
    ) u_rmux (
        .addr   (io_addr),
        .index  (index_q),
        .core   (core_q),
        .shadow (cfg_shadow),
        .latch  (latch_q),
        .rdata  (io_rdata)
    );

    assign cfg_clock  = core_q.clock;
    assign cfg_periph = core_q.periph;
    assign cfg_paging = core_q.paging;
    assign cfg_power  = core_q.power;
    assign cfg_dram   = core_q.dram;
    assign cfg_bound  = core_q.bound;
    assign cfg_romen  = core_q.romen;
    assign cfg_wprot  = core_q.wprot;
endmodule

// File: rtl/cfg_index_port_checker.sv
module cfg_index_port_checker #(
    parameter int            AW          = 16,
    parameter logic [AW-1:0] DATA_PORT   = 16'h0023,
    parameter logic [AW-1:0] SYSCTL_PORT = 16'h0092
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr,
    input logic [AW-1:0] io_addr,
    input logic [7:0]    io_wdata,
    input logic [7:0]    io_rdata,
    input logic [7:0]    index_q,
    input logic [7:0]    cfg_power,
    input logic          a20_alt,
    input logic          cpu_soft_reset,
    input logic          remap_stb
);
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_soft_reset |=> !cpu_soft_reset);

    a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_soft_reset |-> $past(io_wr && (io_addr == SYSCTL_PORT) && io_wdata[0]));

    a_r6_a20_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == SYSCTL_PORT)) |=> (a20_alt == $past(io_wdata[1])));

    a_r8_stb_cause: assert property (@(posedge clk) disable iff (!rst_n)
        remap_stb |-> $past(io_wr && (io_addr == DATA_PORT)));

    a_r8_stb_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (io_addr == DATA_PORT) && (index_q == 8'h45)) |=> remap_stb);

    a_r4_power_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_power & 8'hBF) == 8'h00);

    a_r5_status_live: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_addr == DATA_PORT) && (index_q == 8'h43)) |-> (io_rdata[6] == a20_alt));

    a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_addr != DATA_PORT) && (io_addr != SYSCTL_PORT)) |-> (io_rdata == 8'hFF));
endmodule

bind cfg_index_port cfg_index_port_checker #(
    .AW          (AW),
    .DATA_PORT   (DATA_PORT),
    .SYSCTL_PORT (SYSCTL_PORT)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .io_wr          (io_wr),
    .io_addr        (io_addr),
    .io_wdata       (io_wdata),
    .io_rdata       (io_rdata),
    .index_q        (index_q),
    .cfg_power      (cfg_power),
    .a20_alt        (a20_alt),
    .cpu_soft_reset (cpu_soft_reset),
    .remap_stb      (remap_stb)
);

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [7:0]  cfg_clock, cfg_periph, cfg_paging, cfg_power;
    logic [7:0]  cfg_dram, cfg_bound, cfg_romen, cfg_wprot;
    logic [23:0] cfg_shadow;
    logic        a20_alt, cpu_soft_reset, remap_stb;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic seen_rst, seen_stb;
    logic [7:0] mdl [256];
    logic [7:0] latch_m;

    always #2 clk = ~clk;

    cfg_index_port i_cfg_index_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_clock(cfg_clock), .cfg_periph(cfg_periph), .cfg_paging(cfg_paging),
        .cfg_power(cfg_power), .cfg_dram(cfg_dram), .cfg_bound(cfg_bound),
        .cfg_romen(cfg_romen), .cfg_wprot(cfg_wprot), .cfg_shadow(cfg_shadow),
        .a20_alt(a20_alt), .cpu_soft_reset(cpu_soft_reset), .remap_stb(remap_stb)
    );

    function automatic logic [7:0] reset_val(input int ix);
        case (ix)
            8'h01: return 8'h00;
            8'h40: return 8'h0A;
            8'h41: return 8'h02;
            8'h42: return 8'h80;
            8'h43: return 8'h37;
            8'h44, 8'h46, 8'h47, 8'h49, 8'h4A, 8'h4B, 8'h4C: return 8'h00;
            8'h45: return 8'h02;
            8'h48: return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic bit writable(input int ix);
        return (ix >= 8'h41 && ix <= 8'h4C && ix != 8'h43);
    endfunction

    function automatic logic [7:0] expect_read(input int ix);
        logic [7:0] v;
        v = mdl[ix];
        if (ix == 8'h43) v[6] = latch_m[1];
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1;
        seen_rst = cpu_soft_reset;
        seen_stb = remap_stb;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        latch_m = 8'h00;
        for (int i = 0; i < 256; i++) mdl[i] = reset_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values on every index
        for (int i = 0; i < 256; i++) begin
            io_write(16'h0022, 8'(i));
            io_read(16'h0023, rd);
            chk($sformatf("R2 reset idx %0h", i), rd, expect_read(i));
        end
        io_read(16'h0092, rd);
        chk("R6 latch reset", rd, 8'h00);
        chk("R6 a20 reset", a20_alt, 1'b0);
        chk("R10 clock out reset", cfg_clock, 8'h02);
        chk("R10 romen out reset", cfg_romen, 8'hC0);

        // R9: unmapped addresses
        for (int a = 16'h0020; a < 16'h0098; a++) begin
            if (a != 16'h0023 && a != 16'h0092) begin
                io_read(16'(a), rd);
                chk("R9 unmapped read", rd, 8'hFF);
            end
        end

        // R1 R3 R4 R8: write sweep over all indices
        for (int i = 0; i < 256; i++) begin
            logic [7:0] pat;
            pat = 8'(i) ^ 8'hA5;
            io_write(16'h0022, 8'(i));
            io_write(16'h0023, pat);
            chk($sformatf("R8 stb idx %0h", i), seen_stb, (i == 8'h45 || i == 8'h46));
            @(negedge clk);
            chk("R8 stb one cycle", remap_stb, 1'b0);
            if (writable(i)) mdl[i] = (i == 8'h44) ? (pat & 8'h40) : pat;
            io_read(16'h0023, rd);
            chk($sformatf("R1 R3 R4 readback idx %0h", i), rd, expect_read(i));
        end
        // R3: no write disturbed any other slot
        for (int i = 0; i < 256; i++) begin
            io_write(16'h0022, 8'(i));
            io_read(16'h0023, rd);
            chk($sformatf("R3 retained idx %0h", i), rd, expect_read(i));
        end
        // R4: all-ones power write
        io_write(16'h0022, 8'h44);
        io_write(16'h0023, 8'hFF);
        io_read(16'h0023, rd);
        chk("R4 power mask", rd, 8'h40);
        mdl[8'h44] = 8'h40;
        // R10: outputs
        chk("R10 clock", cfg_clock, mdl[8'h41]);
        chk("R10 periph", cfg_periph, mdl[8'h42]);
        chk("R10 power", cfg_power, mdl[8'h44]);
        chk("R10 dram", cfg_dram, mdl[8'h45]);
        chk("R10 bound", cfg_bound, mdl[8'h46]);
        chk("R10 paging", cfg_paging, mdl[8'h47]);
        chk("R10 romen", cfg_romen, mdl[8'h48]);
        chk("R10 wprot", cfg_wprot, mdl[8'h49]);
        chk("R10 shadow", cfg_shadow, {mdl[8'h4C], mdl[8'h4B], mdl[8'h4A]});

        // R6 R7 R5: system control latch sweep
        for (int v = 0; v < 256; v++) begin
            logic exp_p;
            exp_p = v[0] & ~latch_m[0];
            io_write(16'h0092, 8'(v));
            chk($sformatf("R7 pulse v=%0h", v), seen_rst, exp_p);
            @(negedge clk);
            chk("R7 pulse one cycle", cpu_soft_reset, 1'b0);
            latch_m = 8'(v);
            chk("R6 a20", a20_alt, latch_m[1]);
            io_read(16'h0092, rd);
            chk("R6 latch readback", rd, latch_m);
            io_write(16'h0022, 8'h43);
            io_read(16'h0023, rd);
            chk("R5 status live bit", rd, expect_read(8'h43));
        end
        // R7: repeated set gives no pulse
        io_write(16'h0092, 8'h01);
        io_write(16'h0092, 8'h01);
        chk("R7 no pulse on held bit", seen_rst, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule